// File: doc/BRIEF.md
# Byte/Word Selectable Memory Bus Front End

This block is the bus-side face of a parallel memory that can be wired either as a 16-bit device or as an 8-bit device. A mode input picks the organisation. In 16-bit organisation every data line carries one bit of the addressed word. In 8-bit organisation the most significant data line becomes an extra, least significant address input. It chooses which half of the addressed word is returned, and that half always comes out on the eight low data lines.

The bus is modelled synchronously. Each data line is split into an input, an output and a per-line output enable, so the enable is the tri-state control. Reads return a word from an internal array, or a status byte when the command side asks for one. Write cycles are detected from the rising edge of the write enable. Each one becomes a one-cycle command strobe carrying the full byte address and the low data byte, and that strobe feeds a command decoder outside this block. Chip enable gates everything else.

Top module: `membus_byteword`

## Requirements
- R1: With `word_mode`=1 an active read drives all 16 lines (`dq_oe`=16'hFFFF); with `word_mode`=0 it drives exactly lines 7..0 (`dq_oe`=16'h00FF).
- R2: With `word_mode`=0, `dq_i[15]` is the byte address bit. A 0 returns bits 7..0 of the addressed word on `dq_o[7:0]`, a 1 returns bits 15..8 on `dq_o[7:0]`, and the same bit becomes `cmd_addr[0]` of a write command.
- R3: With `word_mode`=0, lines 14..8 (and line 15, which is then an input) are never driven.
- R4: While `ce_n`=1 no line is driven, no command strobe is produced, and a write-enable rise during that time does not create a command.
- R5: A write command carries only `dq_i[7:0]` in `cmd_data`; `dq_i[14:8]` have no effect on it.
- R6: With `word_mode`=1 a read returns the whole word with bit 15 on `dq_o[15]`, and a write command has `cmd_addr[0]`=0.
- R7: Lines are driven only on the clock edge after one at which `ce_n`=0, `oe_n`=0 and `we_n`=1 are sampled; otherwise `dq_oe`=0.
- R8: `cmd_vld` is high for exactly one cycle after a clock edge at which `we_n` is sampled 1, provided it was sampled 0 at the previous edge and `ce_n` was 0 at both edges. It then carries `cmd_addr`={`addr`, byte bit}.
- R9: After reset the array holds, at word address a, low byte (a*37+3) mod 256 and high byte equal to that low byte XOR 8'hC3.
- R10: With `stat_rd`=1 a read returns `stat_val` on lines 7..0 in both organisations, and lines 15..8 read zero in 16-bit organisation.
- R11: During reset `dq_oe`=0 and `cmd_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| word_mode | input | 1 | 1: 16-bit organisation, 0: 8-bit organisation |
| addr | input | ADDR_W | Word address |
| dq_i | input | 16 | Data lines as seen from the bus; bit 15 is the byte address in 8-bit organisation |
| dq_o | output | 16 | Data driven onto the bus |
| dq_oe | output | 16 | Per-line output enable (tri-state control) |
| stat_rd | input | 1 | Status read requested by the command side |
| stat_val | input | 8 | Status byte to return |
| cmd_vld | output | 1 | One-cycle write command strobe |
| cmd_addr | output | ADDR_W+1 | Byte address of the write: {addr, byte bit} |
| cmd_data | output | 8 | Low data byte of the write |

## Verification
Both result paths have one cycle of latency. Read data and lane enables reflect the inputs sampled at a clock edge and are valid just after that edge. A command strobe follows the edge at which the write enable is first seen high again. The bench's behavioural model computes its expectations at each rising edge from the inputs held stable there. It compares every output at the next falling edge, and at that falling edge the bench also changes its stimulus, so each comparison lands exactly one register stage after its cause. Read data are compared only on lines the model expects to be driven.

// File: rtl/membus_pkg.sv
package membus_pkg;

   localparam int LANE_W = 8;
   localparam int DQ_W   = 2 * LANE_W;

   typedef enum logic [1:0] {
      LANE_IDLE = 2'd0,
      LANE_BYTE = 2'd1,
      LANE_WORD = 2'd2
   } lane_mode_e;

   typedef struct packed {
      logic              vld;
      logic [LANE_W-1:0] data;
   } cmd_beat_t;

   // Content loaded into the word array at reset.
   function automatic logic [DQ_W-1:0] seed_word(input int unsigned idx);
      logic [LANE_W-1:0] lo;
      lo = LANE_W'((idx * 37 + 3) % 256);
      return {lo ^ 8'hC3, lo};
   endfunction

endpackage

// File: rtl/mb_lane_decode.sv
module mb_lane_decode
   import membus_pkg::*;
(
   input  logic            ce_n,
   input  logic            oe_n,
   input  logic            we_n,
   input  logic            word_mode,
   input  logic            dq15_in,
   output lane_mode_e      lane_mode,
   output logic            byte_hi,
   output logic [DQ_W-1:0] line_oe
);

   logic rd_act;

   assign rd_act  = ~ce_n & ~oe_n & we_n;
   assign byte_hi = ~word_mode & dq15_in;

   always_comb begin
      if (!rd_act)        lane_mode = LANE_IDLE;
      else if (word_mode) lane_mode = LANE_WORD;
      else                lane_mode = LANE_BYTE;
   end

   // Low lanes drive in either organisation; upper lanes only in word mode.
   for (genvar g = 0; g < DQ_W; g++) begin : g_line
      if (g < LANE_W) begin : g_low
         assign line_oe[g] = (lane_mode != LANE_IDLE);
      end else begin : g_high
         assign line_oe[g] = (lane_mode == LANE_WORD);
      end
   end

endmodule

// File: rtl/mb_word_array.sv
module mb_word_array
   import membus_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DQ_W-1:0]   rd_word
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DQ_W-1:0] store_q [DEPTH];

   // Contents are loaded at reset and held; writes go to the command side.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            store_q[i] <= seed_word(i);
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            store_q[i] <= store_q[i];
         end
      end
   end

   assign rd_word = store_q[rd_addr];

endmodule

// File: rtl/mb_read_mux.sv
module mb_read_mux
   import membus_pkg::*;
(
   input  lane_mode_e        lane_mode,
   input  logic              byte_hi,
   input  logic [DQ_W-1:0]   word_in,
   input  logic              stat_rd,
   input  logic [LANE_W-1:0] stat_val,
   output logic [DQ_W-1:0]   data_out
);

   logic [LANE_W-1:0] sel_byte;

   assign sel_byte = byte_hi ? word_in[DQ_W-1:LANE_W] : word_in[LANE_W-1:0];

   always_comb begin
      data_out = '0;
      unique case (lane_mode)
         LANE_WORD: data_out = stat_rd ? {{LANE_W{1'b0}}, stat_val} : word_in;
         LANE_BYTE: data_out = {{LANE_W{1'b0}}, (stat_rd ? stat_val : sel_byte)};
         default:   data_out = '0;
      endcase
   end

endmodule

// File: rtl/mb_cmd_capture.sv
module mb_cmd_capture
   import membus_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              word_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_i,
   output logic              cmd_vld,
   output logic [ADDR_W:0]   cmd_addr,
   output logic [LANE_W-1:0] cmd_data
);

   logic      we_hist_q;
   logic      rise;
   cmd_beat_t beat_q;
   logic [ADDR_W:0] addr_q;

   // History is forced high while deselected so a rise needs a low under select.
   assign rise = ~ce_n & ~we_hist_q & we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_hist_q <= 1'b1;
         beat_q    <= '0;
         addr_q    <= '0;
      end else begin
         we_hist_q  <= ce_n | we_n;
         beat_q.vld <= rise;
         if (rise) begin
            beat_q.data <= dq_i[LANE_W-1:0];
            addr_q      <= {addr, (~word_mode & dq_i[DQ_W-1])};
         end
      end
   end

   assign cmd_vld  = beat_q.vld;
   assign cmd_data = beat_q.data;
   assign cmd_addr = addr_q;

endmodule

// File: rtl/membus_byteword.sv
module membus_byteword
   import membus_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              word_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       dq_i,
   output logic [15:0]       dq_o,
   output logic [15:0]       dq_oe,
   input  logic              stat_rd,
   input  logic [7:0]        stat_val,
   output logic              cmd_vld,
   output logic [ADDR_W:0]   cmd_addr,
   output logic [7:0]        cmd_data
);

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_chk_aw
      $error("membus_byteword: ADDR_W must be within 1..12");
   end
   if (DQ_W != 16) begin : g_chk_dq
      $error("membus_byteword: bus width must be 16");
   end

   lane_mode_e      lane_mode;
   logic            byte_hi;
   logic [DQ_W-1:0] line_oe;
   logic [DQ_W-1:0] rd_word;
   logic [DQ_W-1:0] rd_data;

   mb_lane_decode u_dec (
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .we_n      (we_n),
      .word_mode (word_mode),
      .dq15_in   (dq_i[DQ_W-1]),
      .lane_mode (lane_mode),
      .byte_hi   (byte_hi),
      .line_oe   (line_oe)
   );

   mb_word_array #(.ADDR_W(ADDR_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (addr),
      .rd_word (rd_word)
   );

   mb_read_mux u_mux (
      .lane_mode (lane_mode),
      .byte_hi   (byte_hi),
      .word_in   (rd_word),
      .stat_rd   (stat_rd),
      .stat_val  (stat_val),
      .data_out  (rd_data)
   );

   mb_cmd_capture #(.ADDR_W(ADDR_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .we_n      (we_n),
      .word_mode (word_mode),
      .addr      (addr),
      .dq_i      (dq_i),
      .cmd_vld   (cmd_vld),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data)
   );

   if (OUT_REG) begin : g_out_reg
      logic [DQ_W-1:0] oe_q, o_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            oe_q <= '0;
            o_q  <= '0;
         end else begin
            oe_q <= line_oe;
            o_q  <= rd_data & line_oe;
         end
      end
      assign dq_oe = oe_q;
      assign dq_o  = o_q;
   end else begin : g_out_comb
      assign dq_oe = rst_n ? line_oe : '0;
      assign dq_o  = rst_n ? (rd_data & line_oe) : '0;
   end

endmodule

// File: rtl/membus_byteword_chk.sv
module mb_bus_checker #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              word_mode,
   input logic [ADDR_W-1:0] addr,
   input logic [15:0]       dq_i,
   input logic [15:0]       dq_o,
   input logic [15:0]       dq_oe,
   input logic              stat_rd,
   input logic [7:0]        stat_val,
   input logic              cmd_vld,
   input logic [ADDR_W:0]   cmd_addr,
   input logic [7:0]        cmd_data
);

   AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && we_n && word_mode) |=> (dq_oe == 16'hFFFF)); // R1

   AST_BYTE_LOW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && we_n && !word_mode) |=> (dq_oe == 16'h00FF)); // R3

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (dq_oe == 16'h0000 && !cmd_vld)); // R4

   AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n || !we_n) |=> (dq_oe == 16'h0000)); // R7

   AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |-> ($past(we_n) && !$past(ce_n))); // R8

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |=> !cmd_vld); // R8

   AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && we_n && word_mode && stat_rd) |=> (dq_o[15:8] == 8'h00)); // R10

endmodule

bind membus_byteword mb_bus_checker #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/membus_byteword_tb.sv
module membus_byteword_tb_top;

   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, word_mode = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [15:0]   dq_i = '0;
   logic [15:0]   dq_o, dq_oe;
   logic          stat_rd = 1'b0;
   logic [7:0]    stat_val = '0;
   logic          cmd_vld;
   logic [AW:0]   cmd_addr;
   logic [7:0]    cmd_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit armed  = 0;
   bit done   = 0;

   membus_byteword #(.ADDR_W(AW)) dut_i (.*);

   always #5 clk = ~clk;

   // Reference model state
   logic [15:0] m_oe, m_o;
   logic        m_vld, m_weh;
   logic [AW:0] m_addr;
   logic [7:0]  m_data;

   function automatic logic [15:0] ref_word(input int a);
      int lo;
      lo = (a * 37 + 3) % 256;
      return {8'(lo) ^ 8'hC3, 8'(lo)};
   endfunction

   always @(posedge clk) begin
      logic [15:0] w;
      armed <= 1'b1;
      if (!rst_n) begin
         m_oe = 0; m_o = 0; m_vld = 0; m_weh = 1; m_addr = 0; m_data = 0;
      end else begin
         w = ref_word(int'(addr));
         m_oe = 0; m_o = 0;
         if (!ce_n && !oe_n && we_n) begin
            if (word_mode) begin
               m_oe = 16'hFFFF;
               m_o  = stat_rd ? {8'h00, stat_val} : w;
            end else begin
               m_oe = 16'h00FF;
               m_o  = {8'h00, stat_rd ? stat_val : (dq_i[15] ? w[15:8] : w[7:0])};
            end
         end
         m_vld = !ce_n && !m_weh && we_n;
         if (m_vld) begin
            m_addr = {addr, word_mode ? 1'b0 : dq_i[15]};
            m_data = dq_i[7:0];
         end
         m_weh = ce_n ? 1'b1 : we_n;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (armed && !done) begin
         if (!rst_n) begin
            chk("R11 enables in reset", 32'(dq_oe), 32'h0);
            chk("R11 strobe in reset", 32'(cmd_vld), 32'h0);
         end else begin
            chk("R1/R3/R4/R7 lane enables", 32'(dq_oe), 32'(m_oe));
            chk("R2/R6/R9/R10 read data", 32'(dq_o & m_oe), 32'(m_o));
            chk("R4/R8 command strobe", 32'(cmd_vld), 32'(m_vld));
            if (m_vld) begin
               chk("R2/R6/R8 command address", 32'(cmd_addr), 32'(m_addr));
               chk("R5 command data", 32'(cmd_data), 32'(m_data));
            end
         end
      end
      if (cycles > 20000 && !done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_read(input int a, input logic wm, input logic hi, input logic st);
      @(negedge clk);
      ce_n = 0; oe_n = 0; we_n = 1; word_mode = wm; addr = AW'(a);
      dq_i = {hi, 15'h5A5A}; stat_rd = st;
      @(negedge clk);
      oe_n = 1; stat_rd = 0;
   endtask

   task automatic bus_write(input int a, input logic [15:0] d, input logic wm, input logic ce);
      @(negedge clk);
      ce_n = ce; oe_n = 1; word_mode = wm; addr = AW'(a); dq_i = d; we_n = 0;
      step(2);
      we_n = 1;
      step(2);
   endtask

   initial begin
      step(3);
      rst_n = 1;                       // R11 checked above during reset
      step(2);
      // R6 R9 R1: word reads across range and boundaries
      bus_read(0, 1, 0, 0);
      bus_read(255, 1, 0, 0);
      bus_read(77, 1, 1, 0);
      // R2 R3: byte reads of both halves
      bus_read(12, 0, 0, 0);
      bus_read(12, 0, 1, 0);
      bus_read(255, 0, 1, 0);
      // R10: status reads in each organisation
      stat_val = 8'h9C;
      bus_read(5, 1, 0, 1);
      bus_read(5, 0, 1, 1);
      // R5 R6 R8: word-mode write with junk upper lines
      bus_write(33, 16'hFE42, 1, 0);
      // R2 R8: byte-mode write to high byte
      bus_write(200, 16'h8017, 0, 0);
      bus_write(201, 16'h7F01, 0, 0);
      // R4: deselected read and write
      @(negedge clk);
      ce_n = 1; oe_n = 0; we_n = 1;
      step(2);
      bus_write(9, 16'h00AA, 1, 1);
      // R4: select drops before the write enable rises
      @(negedge clk);
      ce_n = 0; oe_n = 1; we_n = 0;
      step(1);
      ce_n = 1;
      step(1);
      we_n = 1;
      step(2);
      // R7: output enable high, and write enable low, give no drive
      @(negedge clk);
      ce_n = 0; oe_n = 1; we_n = 1;
      step(2);
      oe_n = 0; we_n = 0;
      step(2);
      we_n = 1;
      step(3);
      oe_n = 1; ce_n = 1;
      step(3);
      // R11: reset mid-run
      rst_n = 0;
      step(2);
      rst_n = 1;
      step(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule